// File: doc/BRIEF.md
# Speculative Identity Preload Controller

This block sits between an accelerator's load/store port and two downstream services: an access checker, which decides whether a virtual address may be used as-is, and the data memory. Most pages are expected to be identity mapped, so the physical address equals the virtual one. A read is therefore sent to memory at its virtual address in the same cycle that the check is requested. The check costs no time unless it turns out slower than the memory.

The checker can return one of three verdicts. On a grant, the preloaded word is handed back. On a denial, the preloaded word is dropped and the requester receives a fault. On a remap, the checker supplies a translated address; the preloaded word is dropped and the read is sent again to that address. Writes are never sent ahead of the check. A write goes out once, after a grant (at its own address) or a remap (at the translated address). The controller holds one request at a time. A read finishes only after both the check and the preload have answered, in whichever order they arrive.

Top module: `spec_preload_ctrl`

## Requirements
- R1: When a read is accepted, `chk_req_valid` and `mem_req_valid` are both high in that same cycle, and both carry the request address.
- R2: On a grant verdict (`chk_rsp_kind` = 2'b00), a read completes with status OK (`rsp_fault` = 0). Its data is the preloaded word, and exactly one memory request is issued.
- R3: On a denial verdict (2'b01, and the unused code 2'b11), the response has `rsp_fault` = 1 and `rsp_rdata` = 0. A read issues only its preload. A write issues no memory request at all.
- R4: On a remap verdict (2'b10), a read issues a second memory read at `chk_rsp_paddr`, returns that word with status OK, and issues exactly two memory requests.
- R5: For a granted read whose check answers within 4 cycles and no later than memory, `rsp_valid` rises L+1 cycles after the accept cycle, where memory answers L cycles after its request.
- R6: A write issues no memory request before its verdict arrives. After a grant or remap, it issues exactly one write, at the request address or the translated address respectively, and answers OK with zero data.
- R7: Only one request is outstanding. `req_ready` is low from the accept until the response is taken, and a request offered meanwhile issues no traffic. A read answers one cycle after the later of the check and preload answers, so a slow check delays it.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_fault` and `rsp_rdata` hold their values.
- R9: During and after reset, with no request offered, `req_ready` = 1 while `rsp_valid`, `chk_req_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Accelerator request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Virtual address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | 0 = OK, 1 = FAULT |
| rsp_rdata | output | DATA_W | Read data (zero on fault or write) |
| chk_req_valid | output | 1 | Access check request (one-cycle pulse) |
| chk_req_addr | output | ADDR_W | Address to check |
| chk_rsp_valid | input | 1 | Verdict available (one-cycle pulse) |
| chk_rsp_kind | input | 2 | 00 grant, 01 deny, 10 remap |
| chk_rsp_paddr | input | ADDR_W | Translated address on remap |
| mem_req_valid | output | 1 | Memory request (one-cycle pulse) |
| mem_req_write | output | 1 | Memory write when high |
| mem_req_addr | output | ADDR_W | Physical address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory answer (one-cycle pulse) |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
The assertions assume the following about the environment. The checker and the memory each answer every request exactly once, with a one-cycle pulse, at least one cycle after the request. Neither ever answers when nothing is pending. A verdict code outside the three defined ones is treated as a denial. The bench enforces these assumptions with its two response models. Each model arms a countdown only when it sees a request pulse and answers once when the countdown expires, with a latency of at least one. The models also log every memory request so that the traffic can be compared with the verdict.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the speculative preload controller.
// Assumes: verdict codes are fixed by the access checker interface.
package spc_pkg;
    localparam logic [1:0] VK_GRANT = 2'b00;
    localparam logic [1:0] VK_DENY  = 2'b01;
    localparam logic [1:0] VK_REMAP = 2'b10;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_WAIT, S_WR_WAIT, S_ISSUE, S_MEM_WAIT, S_HOLD
    } seq_state_e;
endpackage

// File: rtl/spc_seq.sv
`timescale 1ns/1ps
// Request sequencer: accepts one request, launches check and preload,
// merges the two answers, reissues or writes after the verdict, and
// signals completion to the response register.
// Assumes: check and memory answer each request exactly once, one cycle
// or more after it, and never while nothing is pending.
module spc_seq
    import spc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              chk_req_valid,
    output logic [ADDR_W-1:0] chk_req_addr,
    input  logic              chk_rsp_valid,
    input  logic [1:0]        chk_rsp_kind,
    input  logic [ADDR_W-1:0] chk_rsp_paddr,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    input  logic              rsp_fire,
    output logic              done,
    output logic              done_fault,
    output logic [DATA_W-1:0] done_data
);
    seq_state_e        state_q, state_d;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q, tgt_q, tgt_d;
    logic [DATA_W-1:0] wdata_q, pre_q;
    logic              chk_got_q, mem_got_q;
    logic [1:0]        kind_q;
    logic              accept, chk_now, mem_now;
    logic [1:0]        kind_now;
    logic [DATA_W-1:0] data_now;

    // Merge answers already held with answers arriving this cycle.
    always_comb begin
        accept   = (state_q == S_IDLE) && req_valid;
        chk_now  = chk_got_q || chk_rsp_valid;
        mem_now  = mem_got_q || mem_rsp_valid;
        kind_now = chk_rsp_valid ? chk_rsp_kind : kind_q;
        data_now = mem_rsp_valid ? mem_rsp_rdata : pre_q;
    end

    // Drive check and memory requests; reads launch both together.
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        chk_req_valid = accept;
        chk_req_addr  = req_addr;
        mem_req_valid = (accept && !req_write) || (state_q == S_ISSUE);
        mem_req_write = (state_q == S_ISSUE) && write_q;
        mem_req_addr  = (state_q == S_ISSUE) ? tgt_q : req_addr;
        mem_req_wdata = wdata_q;
    end

    // Next state and completion decision.
    always_comb begin
        state_d    = state_q;
        tgt_d      = tgt_q;
        done       = 1'b0;
        done_fault = 1'b0;
        done_data  = '0;
        case (state_q)
            S_IDLE: if (accept) state_d = req_write ? S_WR_WAIT : S_RD_WAIT;
            S_RD_WAIT: begin
                if (chk_rsp_valid) tgt_d = chk_rsp_paddr;
                if (chk_now && mem_now) begin
                    if (kind_now == VK_GRANT) begin
                        done      = 1'b1;
                        done_data = data_now;
                        state_d   = S_HOLD;
                    end else if (kind_now == VK_REMAP) begin
                        state_d = S_ISSUE;
                    end else begin
                        done       = 1'b1;
                        done_fault = 1'b1;
                        state_d    = S_HOLD;
                    end
                end
            end
            S_WR_WAIT: if (chk_rsp_valid) begin
                if (chk_rsp_kind == VK_GRANT) begin
                    tgt_d   = addr_q;
                    state_d = S_ISSUE;
                end else if (chk_rsp_kind == VK_REMAP) begin
                    tgt_d   = chk_rsp_paddr;
                    state_d = S_ISSUE;
                end else begin
                    done       = 1'b1;
                    done_fault = 1'b1;
                    state_d    = S_HOLD;
                end
            end
            S_ISSUE: state_d = S_MEM_WAIT;
            S_MEM_WAIT: if (mem_rsp_valid) begin
                done      = 1'b1;
                done_data = write_q ? '0 : mem_rsp_rdata;
                state_d   = S_HOLD;
            end
            S_HOLD: if (rsp_fire) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State, captured request and early answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            write_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            tgt_q     <= '0;
            pre_q     <= '0;
            kind_q    <= VK_DENY;
            chk_got_q <= 1'b0;
            mem_got_q <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            if (accept) begin
                write_q   <= req_write;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                chk_got_q <= 1'b0;
                mem_got_q <= 1'b0;
            end else if (state_q == S_RD_WAIT) begin
                if (chk_rsp_valid) begin
                    chk_got_q <= 1'b1;
                    kind_q    <= chk_rsp_kind;
                end
                if (mem_rsp_valid) begin
                    mem_got_q <= 1'b1;
                    pre_q     <= mem_rsp_rdata;
                end
            end
        end
    end

    // R1: a read's preload goes out with its check, at the same address.
    a_r1_preload_with_check: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req_valid && !req_write) |-> (mem_req_valid && !mem_req_write && mem_req_addr == chk_req_addr));
    // R6: a memory write never coincides with the start of its own check.
    a_r6_write_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !chk_req_valid);
    // R7: memory requests are single pulses; never two back to back.
    a_r7_single_mem_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R7: a check request is never followed by another in the next cycle.
    a_r7_single_chk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req_valid |=> !chk_req_valid);
endmodule

// File: rtl/spc_rsp_reg.sv
`timescale 1ns/1ps
// Response register: loads a completion, holds it until the requester
// takes it.
// Assumes: load never arrives while a response is still held.
module spc_rsp_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_fault,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Capture a completion; clear once it is handed over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_fault <= load_fault;
            rsp_rdata <= load_fault ? '0 : load_data;
        end else if (rsp_valid && rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R8: a stalled response keeps every field.
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_rdata)));
    // R3: a faulting response carries no data.
    a_r3_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_rdata == '0));
endmodule

// File: rtl/spec_preload_ctrl.sv
`timescale 1ns/1ps
// Top: speculative identity preload controller. Reads fetch at the
// virtual address while the access check runs; the verdict commits,
// drops or reissues the fetch. Writes wait for the verdict.
// Assumes: one outstanding request; check and memory ports always accept.
module spec_preload_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              chk_req_valid,
    output logic [ADDR_W-1:0] chk_req_addr,
    input  logic              chk_rsp_valid,
    input  logic [1:0]        chk_rsp_kind,
    input  logic [ADDR_W-1:0] chk_rsp_paddr,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);
    logic              done, done_fault, rsp_fire;
    logic [DATA_W-1:0] done_data;

    // Handover of the held response.
    always_comb rsp_fire = rsp_valid && rsp_ready;

    spc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .chk_req_valid(chk_req_valid), .chk_req_addr(chk_req_addr),
        .chk_rsp_valid(chk_rsp_valid), .chk_rsp_kind(chk_rsp_kind),
        .chk_rsp_paddr(chk_rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rsp_fire(rsp_fire), .done(done), .done_fault(done_fault),
        .done_data(done_data)
    );

    spc_rsp_reg #(.DATA_W(DATA_W)) rsp_i (
        .clk(clk), .rst_n(rst_n),
        .load(done), .load_fault(done_fault), .load_data(done_data),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata)
    );

    // R7: no new request is taken while a response is waiting.
    a_r7_no_accept_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

// File: tb/spec_preload_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: table of transactions walked by one loop, then directed
// reset and back-pressure tests. Check and memory are behavioural models.
module spec_preload_ctrl_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 0, req_write = 0, rsp_ready = 1;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid, rsp_fault;
    logic [DW-1:0] rsp_rdata;
    logic          chk_req_valid, mem_req_valid, mem_req_write;
    logic [AW-1:0] chk_req_addr, mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          chk_rsp_valid = 0, mem_rsp_valid = 0;
    logic [1:0]    chk_rsp_kind = 0;
    logic [AW-1:0] chk_rsp_paddr = '0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    spec_preload_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
        .rsp_rdata(rsp_rdata), .chk_req_valid(chk_req_valid),
        .chk_req_addr(chk_req_addr), .chk_rsp_valid(chk_rsp_valid),
        .chk_rsp_kind(chk_rsp_kind), .chk_rsp_paddr(chk_rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int checks = 0, failures = 0;
    task automatic chk(input string rq, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Model state.
    int            m_vlat = 1, m_mlat = 1, vcnt = 0, mcnt = 0;
    logic [1:0]    m_kind = 0;
    logic [AW-1:0] m_paddr = '0, pend_addr = '0, last_maddr = '0, first_maddr = '0;
    int            mem_count = 0, chk_count = 0;
    logic          same_cycle = 0, last_mwrite = 0;
    logic [DW-1:0] store [16];

    // Access check model: answers once, m_vlat cycles after a request.
    initial forever begin
        @(negedge clk);
        chk_rsp_valid = 0;
        if (vcnt > 0) begin
            vcnt--;
            if (vcnt == 0) begin
                chk_rsp_valid = 1; chk_rsp_kind = m_kind; chk_rsp_paddr = m_paddr;
            end
        end
        if (chk_req_valid) begin
            vcnt = m_vlat; chk_count++;
            same_cycle = mem_req_valid && (mem_req_addr == chk_req_addr);
        end
    end

    // Memory model: answers once, m_mlat cycles after a request; logs traffic.
    initial begin
        for (int i = 0; i < 16; i++) store[i] = (i * 32'h01010101) ^ 32'hC0DE0000;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 0) begin
                    mem_rsp_valid = 1; mem_rsp_rdata = store[pend_addr[5:2]];
                end
            end
            if (mem_req_valid) begin
                mcnt = m_mlat; pend_addr = mem_req_addr;
                if (mem_count == 0) first_maddr = mem_req_addr;
                mem_count++; last_maddr = mem_req_addr; last_mwrite = mem_req_write;
                if (mem_req_write) store[mem_req_addr[5:2]] = mem_req_wdata;
            end
        end
    end

    typedef struct packed {
        logic          wr;
        logic [1:0]    kind;
        logic [31:0]   addr;
        logic [31:0]   wdata;
        logic [31:0]   paddr;
        logic [3:0]    vlat;
        logic [3:0]    mlat;
        logic          exp_fault;
        logic [2:0]    exp_nmem;
        logic [7:0]    exp_lat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 32'h10, 32'h0,        32'h0,  4'd1, 4'd3, 1'b0, 3'd1, 8'd4},
        '{1'b0, 2'b00, 32'h14, 32'h0,        32'h0,  4'd4, 4'd4, 1'b0, 3'd1, 8'd5},
        '{1'b0, 2'b00, 32'h18, 32'h0,        32'h0,  4'd2, 4'd6, 1'b0, 3'd1, 8'd7},
        '{1'b0, 2'b01, 32'h1C, 32'h0,        32'h0,  4'd3, 4'd2, 1'b1, 3'd1, 8'd4},
        '{1'b0, 2'b10, 32'h20, 32'h0,        32'h08, 4'd2, 4'd3, 1'b0, 3'd2, 8'd8},
        '{1'b1, 2'b00, 32'h24, 32'hDEADBEEF, 32'h0,  4'd2, 4'd2, 1'b0, 3'd1, 8'd6},
        '{1'b0, 2'b00, 32'h24, 32'h0,        32'h0,  4'd1, 4'd2, 1'b0, 3'd1, 8'd3},
        '{1'b1, 2'b10, 32'h28, 32'h12345678, 32'h30, 4'd3, 4'd1, 1'b0, 3'd1, 8'd6},
        '{1'b0, 2'b00, 32'h30, 32'h0,        32'h0,  4'd1, 4'd1, 1'b0, 3'd1, 8'd2},
        '{1'b1, 2'b01, 32'h34, 32'hFFFF0000, 32'h0,  4'd2, 4'd1, 1'b1, 3'd0, 8'd3},
        '{1'b0, 2'b00, 32'h38, 32'h0,        32'h0,  4'd7, 4'd2, 1'b0, 3'd1, 8'd8},
        '{1'b0, 2'b10, 32'h3C, 32'h04,       32'h04, 4'd1, 4'd5, 1'b0, 3'd2, 8'd12}
    };

    // One transaction; hold_n cycles of response back-pressure.
    task automatic run_txn(input vec_t v, input int hold_n);
        int k;
        logic [DW-1:0] got_data, exp_data;
        logic          got_fault;
        logic [AW-1:0] tgt;
        m_vlat = int'(v.vlat); m_mlat = int'(v.mlat); m_kind = v.kind; m_paddr = v.paddr;
        mem_count = 0; chk_count = 0; same_cycle = 0;
        tgt = (v.kind == 2'b10) ? v.paddr : v.addr;
        @(posedge clk); #1;
        req_valid = 1; req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
        rsp_ready = (hold_n == 0);
        @(negedge clk);
        @(posedge clk); #1;
        req_valid = 0;
        k = 1;
        forever begin
            @(negedge clk);
            if (rsp_valid) break;
            k++;
            if (k > 200) begin
                chk("R7 watchdog waiting for response", 1'b0, 32'(k), 32'd0);
                return;
            end
        end
        got_data = rsp_rdata; got_fault = rsp_fault;
        for (int h = 0; h < hold_n; h++) begin
            @(posedge clk); #1;
            req_valid = 1; req_write = 0; req_addr = 32'h3C;
            @(negedge clk);
            chk("R8 valid held under back-pressure", rsp_valid == 1, 32'(rsp_valid), 32'd1);
            chk("R8 data held under back-pressure", rsp_rdata == got_data, rsp_rdata, got_data);
            chk("R7 req_ready low while busy", req_ready == 0, 32'(req_ready), 32'd0);
        end
        if (hold_n > 0) begin
            @(posedge clk); #1;
            req_valid = 0; rsp_ready = 1;
            @(negedge clk);
        end
        @(posedge clk); #1;
        exp_data = (v.wr || v.exp_fault) ? '0 : store[tgt[5:2]];
        chk(v.exp_fault ? "R3 fault status" : "R2 OK status", got_fault == v.exp_fault,
            32'(got_fault), 32'(v.exp_fault));
        chk(v.wr ? "R6 write returns zero" : (v.kind == 2'b10 ? "R4 remapped data" : "R2 read data"),
            got_data == exp_data, got_data, exp_data);
        chk(v.exp_fault ? "R3 memory traffic" : (v.kind == 2'b10 && !v.wr ? "R4 memory traffic" : "R6 memory traffic"),
            mem_count == int'(v.exp_nmem), 32'(mem_count), 32'(v.exp_nmem));
        chk("R7 latency after later answer", k == int'(v.exp_lat), 32'(k), 32'(v.exp_lat));
        if (!v.wr) chk("R1 preload issued with check", same_cycle && first_maddr == v.addr,
                       first_maddr, v.addr);
        if (!v.exp_fault && v.exp_nmem != 0)
            chk(v.wr ? "R6 write target address" : "R4 final read address",
                last_maddr == tgt && last_mwrite == v.wr, last_maddr, tgt);
        if (!v.wr && !v.exp_fault && v.kind == 2'b00 && v.vlat <= 4 && v.vlat <= v.mlat)
            chk("R5 check latency hidden", k == int'(v.mlat) + 1, 32'(k), 32'(v.mlat + 1));
    endtask

    // Global watchdog.
    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 req_ready in reset", req_ready == 1, 32'(req_ready), 32'd1);
        chk("R9 rsp_valid in reset", rsp_valid == 0, 32'(rsp_valid), 32'd0);
        chk("R9 no requests in reset", !chk_req_valid && !mem_req_valid,
            {30'd0, chk_req_valid, mem_req_valid}, 32'd0);
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk("R9 idle after reset", req_ready && !rsp_valid, {30'd0, req_ready, rsp_valid}, 32'd2);

        for (int i = 0; i < NV; i++) run_txn(VECS[i], 0);

        // Directed: back-pressure on a granted read; the offered second
        // request must not create traffic while the response is held (R7, R8).
        run_txn('{1'b0, 2'b00, 32'h08, 32'h0, 32'h0, 4'd1, 4'd2, 1'b0, 3'd1, 8'd3}, 3);
        chk("R7 no check issued while busy", chk_count == 1, 32'(chk_count), 32'd1);

        // Directed: unused verdict code behaves as a denial (R3).
        run_txn('{1'b0, 2'b11, 32'h0C, 32'h0, 32'h0, 4'd2, 4'd2, 1'b1, 3'd1, 8'd3}, 0);

        repeat (3) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule